// File: doc/BRIEF.md
# Three-Wire Switch Register Access Master

This block drives the serial management port of an Ethernet switch device. The port has a select line, a clock line and one data line. The master drives the data line for commands and releases it when the target answers. A host hands over one register request at a time on a request/ready handshake. The block then sequences the pins, collects any read data, and reports completion with a one-cycle response strobe. Outside a transaction all three pins are released to high impedance. Each pin has its own output-enable port, so the pad ring can build the tri-state buffers.

Writes and reads use different frames. A write frame is short and is sent with select held high. A read frame is sent with select held low and starts with a long run of ones. After a read frame the data line turns around, two spare clocks follow, and then 32 bits come back from the target. Every transaction starts with a quiet setup phase and ends with two spare clocks. The length of each clock phase is set in system clock cycles by a parameter. With a 50 MHz system clock, a value of 150 gives 3 µs per phase. The data bit changes at the start of each low phase, so it is stable for a whole phase before the rising edge at which the target captures it.

Top module: `mgmt3w_master`

## Requirements
- R1: After reset, all three output enables are low, busy is low, reqReady is high and rspValid is low.
- R2: A write frame is 27 bits, placed on the data line MSB first and valid at each rising clock edge. It consists of a start bit 1, then the opcode bits 0 and 1, then the address bits 7..0, then the data bits 15..0.
- R3: During a write, select is high at every frame clock edge and low at the trailing clock edges. During a read, select stays low throughout.
- R4: A read frame is 46 bits, sent MSB first. It consists of 32 ones, then the bits 0,1,1,0, then the table bit, then two zeros, then address bits 6..1, then a single zero.
- R5: After a read frame, the data output enable drops. Two rising clock edges follow. Then 32 bits are sampled MSB first, each at the end of a low phase, just before its rising edge.
- R6: Each transaction ends with two extra clock pulses. A write gives 29 rising edges in total and a read gives 82.
- R7: Each clock phase lasts PHASE_CYCLES cycles. The transaction begins with one setup phase in which select, clock and data are all enabled and driven 0. A write then holds busy for 60 phases and a read for 167 phases.
- R8: For table 0, an odd address returns bits 31..16 of the captured word and an even address returns bits 15..0, in both cases zero-extended. For table 1, all 32 bits are returned.
- R9: reqReady equals the inverse of busy. A request is accepted only when reqReady is high. A request raised while busy is ignored and starts no later transaction.
- R10: rspValid is high for exactly one cycle, in the cycle where busy falls and all pins are released. rspData is updated only by reads; a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at this edge when high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqTable | input | 1 | Read table select (0 config, 1 counters) |
| reqAddr | input | 8 | Register address |
| reqWdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| rspValid | output | 1 | One-cycle completion strobe |
| rspData | output | 32 | Read result |
| selOut | output | 1 | Select pin value |
| selOe | output | 1 | Select pin output enable |
| sckOut | output | 1 | Clock pin value |
| sckOe | output | 1 | Clock pin output enable |
| sdoOut | output | 1 | Data pin value |
| sdoOe | output | 1 | Data pin output enable |
| sdiIn | input | 1 | Data pin input |

## Verification
A wrong phase counter or state shows up at once as a wrong busy length or a wrong count of rising clock edges, at the end of the same transaction. A fault in the frame shift register or the frame build shows as wrong bits captured at the target-side clock edges. A fault in the turnaround or the sampling shows as a shifted or misselected rspData. A select or enable fault is visible at the very first clock edge, or in the cycle after the request is accepted. A request raised while busy is checked by watching that busy stays low after completion and that the result belongs to the first request.

// File: rtl/mgmt3w_pkg.sv
package mgmt3w_pkg;
  localparam int WR_BITS       = 27;
  localparam int RD_BITS       = 46;
  localparam int PREAMBLE_BITS = 32;
  localparam int RX_BITS       = 32;
  localparam int FRAME_W       = RD_BITS;
  localparam int TAIL_CLOCKS   = 2;
  localparam int TURN_CLOCKS   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SEND, ST_SEND_END, ST_TURN, ST_RECV, ST_RECV_END, ST_TAIL
  } stateT;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic finish;
    logic quiet;
  } strobeT;
endpackage

// File: rtl/mgmt3w_ctrl.sv
module mgmt3w_ctrl
  import mgmt3w_pkg::*;
#(
  parameter int PHASE_CYCLES = 150
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   busy,
  output logic   isWriteQ,
  output logic   selOut,
  output logic   sckOut,
  output logic   sdoOe,
  output logic   pinsOe,
  output strobeT strb
);
  localparam int PH_W   = $clog2(PHASE_CYCLES + 1);
  localparam int STEP_W = $clog2(2 * RD_BITS + 1);

  stateT             state, nextState;
  logic [PH_W-1:0]   phaseCnt;
  logic [STEP_W-1:0] stepCnt, stepLimit;
  logic              phaseEnd, lastStep, accept;

  assign accept   = (state == ST_IDLE) && reqValid;
  assign phaseEnd = phaseCnt == PH_W'(PHASE_CYCLES - 1);
  assign lastStep = stepCnt == (stepLimit - STEP_W'(1));

  always_comb begin
    stepLimit = STEP_W'(1);
    nextState = ST_IDLE;
    case (state)
      ST_SETUP:    begin stepLimit = STEP_W'(1); nextState = ST_SEND; end
      ST_SEND:     begin
        stepLimit = isWriteQ ? STEP_W'(2 * WR_BITS) : STEP_W'(2 * RD_BITS);
        nextState = ST_SEND_END;
      end
      ST_SEND_END: begin stepLimit = STEP_W'(1); nextState = isWriteQ ? ST_TAIL : ST_TURN; end
      ST_TURN:     begin stepLimit = STEP_W'(2 * TURN_CLOCKS); nextState = ST_RECV; end
      ST_RECV:     begin stepLimit = STEP_W'(2 * RX_BITS); nextState = ST_RECV_END; end
      ST_RECV_END: begin stepLimit = STEP_W'(1); nextState = ST_TAIL; end
      ST_TAIL:     begin stepLimit = STEP_W'(2 * TAIL_CLOCKS); nextState = ST_IDLE; end
      default:     begin stepLimit = STEP_W'(1); nextState = ST_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      stepCnt  <= '0;
      isWriteQ <= 1'b0;
    end else if (accept) begin
      state    <= ST_SETUP;
      phaseCnt <= '0;
      stepCnt  <= '0;
      isWriteQ <= reqWrite;
    end else if (state != ST_IDLE) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        if (lastStep) begin
          state   <= nextState;
          stepCnt <= '0;
        end else begin
          stepCnt <= stepCnt + STEP_W'(1);
        end
      end else begin
        phaseCnt <= phaseCnt + PH_W'(1);
      end
    end
  end

  // Pin decode: shifting states start low, spare-clock states start high.
  always_comb begin
    busy   = state != ST_IDLE;
    pinsOe = busy;
    sckOut = 1'b0;
    if (state == ST_SEND || state == ST_RECV) sckOut = stepCnt[0];
    if (state == ST_TURN || state == ST_TAIL) sckOut = ~stepCnt[0];
    selOut = isWriteQ && (state == ST_SEND || state == ST_SEND_END);
    sdoOe  = (state == ST_SETUP) || (state == ST_SEND) || (state == ST_SEND_END) ||
             (isWriteQ && state == ST_TAIL);
    strb.load     = accept;
    strb.shiftOut = (state == ST_SEND) && phaseEnd && stepCnt[0];
    strb.sampleIn = (state == ST_RECV) && phaseEnd && !stepCnt[0];
    strb.finish   = (state == ST_TAIL) && phaseEnd && lastStep;
    strb.quiet    = state == ST_SETUP;
  end

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> busy);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sckOut && !pinsOe && !sdoOe && !selOut));
  p_read_sel_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isWriteQ) |-> !selOut);
  p_turn_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV || state == ST_TURN) |-> !sdoOe);
endmodule

// File: rtl/mgmt3w_dpath.sv
module mgmt3w_dpath
  import mgmt3w_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  strobeT       strb,
  input  logic         isWriteQ,
  input  logic         reqWrite,
  input  logic         reqTable,
  input  logic [7:0]   reqAddr,
  input  logic [15:0]  reqWdata,
  input  logic         sdiIn,
  output logic         sdoOut,
  output logic         rspValid,
  output logic [31:0]  rspData
);
  logic [FRAME_W-1:0] frame;
  logic [RX_BITS-1:0] rxWord;
  logic               tableQ, oddQ;
  logic [31:0]        result;

  always_comb begin
    if (tableQ)    result = rxWord;
    else if (oddQ) result = {16'h0, rxWord[31:16]};
    else           result = {16'h0, rxWord[15:0]};
  end

  assign sdoOut = strb.quiet ? 1'b0 : frame[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame    <= '0;
      rxWord   <= '0;
      tableQ   <= 1'b0;
      oddQ     <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= 1'b0;
      if (strb.load) begin
        tableQ <= reqTable;
        oddQ   <= reqAddr[0];
        if (reqWrite)
          frame <= {1'b1, 2'b01, reqAddr, reqWdata, {(FRAME_W - WR_BITS){1'b0}}};
        else
          frame <= {{PREAMBLE_BITS{1'b1}}, 4'b0110, reqTable, 2'b00, reqAddr[6:1], 1'b0};
      end else if (strb.shiftOut) begin
        frame <= {frame[FRAME_W-2:0], 1'b0};
      end
      if (strb.sampleIn) rxWord <= {rxWord[RX_BITS-2:0], sdiIn};
      if (strb.finish) begin
        rspValid <= 1'b1;
        if (!isWriteQ) rspData <= result;
      end
    end
  end

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  p_sample_read_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleIn |-> !isWriteQ);
  p_frame_drained_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (frame == '0));
endmodule

// File: rtl/mgmt3w_master.sv
module mgmt3w_master
  import mgmt3w_pkg::*;
#(
  parameter int PHASE_CYCLES = 150
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic        reqTable,
  input  logic [7:0]  reqAddr,
  input  logic [15:0] reqWdata,
  output logic        busy,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        selOut,
  output logic        selOe,
  output logic        sckOut,
  output logic        sckOe,
  output logic        sdoOut,
  output logic        sdoOe,
  input  logic        sdiIn
);
  strobeT strb;
  logic   isWriteQ, pinsOe;

  mgmt3w_ctrl #(.PHASE_CYCLES(PHASE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busy(busy), .isWriteQ(isWriteQ), .selOut(selOut), .sckOut(sckOut),
    .sdoOe(sdoOe), .pinsOe(pinsOe), .strb(strb)
  );

  mgmt3w_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .isWriteQ(isWriteQ),
    .reqWrite(reqWrite), .reqTable(reqTable), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .sdiIn(sdiIn), .sdoOut(sdoOut),
    .rspValid(rspValid), .rspData(rspData)
  );

  assign reqReady = !busy;
  assign selOe    = pinsOe;
  assign sckOe    = pinsOe;

  p_done_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!busy && !selOe && !sckOe && !sdoOe));
endmodule

// File: tb/mgmt3w_master_bench.sv
module mgmt3w_master_bench;
  localparam int P = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqTable = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, busy, rspValid, selOut, selOe, sckOut, sckOe, sdoOut, sdoOe, sdiIn;
  logic [31:0] rspData;

  always #10 clk = ~clk;

  mgmt3w_master #(.PHASE_CYCLES(P)) u_mgmt3w_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqTable(reqTable), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .rspValid(rspValid), .rspData(rspData), .selOut(selOut), .selOe(selOe),
    .sckOut(sckOut), .sckOe(sckOe), .sdoOut(sdoOut), .sdoOe(sdoOe), .sdiIn(sdiIn)
  );

  int errors = 0, checks = 0;
  logic clrMon = 1'b0, prevSck = 1'b0;
  int edgeCnt, oeEdges, selEdges, busyCyc, rspCnt, rdEdges;
  logic [63:0] capBits;
  logic [31:0] gotRsp, tgtWord = '0, lastRead = '0;

  assign sdiIn = (rdEdges >= 2 && rdEdges < 34) ? tgtWord[33 - rdEdges] : 1'b0;

  always @(posedge clk) begin
    prevSck <= sckOut;
    if (clrMon) begin
      edgeCnt <= 0; oeEdges <= 0; selEdges <= 0; busyCyc <= 0; rspCnt <= 0;
      rdEdges <= 0; capBits <= '0; gotRsp <= '0;
    end else begin
      if (sckOut && !prevSck) begin
        edgeCnt <= edgeCnt + 1;
        if (sdoOe) begin
          capBits <= {capBits[62:0], sdoOut};
          oeEdges <= oeEdges + 1;
        end else if (sckOe) begin
          rdEdges <= rdEdges + 1;
        end
        if (selOut) selEdges <= selEdges + 1;
      end
      if (busy) busyCyc <= busyCyc + 1;
      if (rspValid) begin
        rspCnt <= rspCnt + 1;
        gotRsp <= rspData;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expResult(input logic t, input logic [7:0] a, input logic [31:0] w);
    if (t) return w;
    return a[0] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  function automatic logic [45:0] expRdFrame(input logic t, input logic [7:0] a);
    return {32'hFFFF_FFFF, 4'b0110, t, 2'b00, a[6:1], 1'b0};
  endfunction

  task automatic runTxn(input logic w, input logic t, input logic [7:0] a,
                        input logic [15:0] d, input logic [31:0] word, input bit poke);
    int wait_n;
    logic [31:0] expR;
    tgtWord = word;
    @(negedge clk) clrMon = 1'b1;
    @(negedge clk) clrMon = 1'b0;
    check(reqReady == 1'b1, "R9 ready before request", reqReady, 1);
    reqValid = 1'b1; reqWrite = w; reqTable = t; reqAddr = a; reqWdata = d;
    @(negedge clk) reqValid = 1'b0;
    // R7: setup phase, all pins enabled and low
    check(selOe && sckOe && sdoOe && !selOut && !sckOut && !sdoOut && busy && !reqReady,
          "R7 setup phase pins", {selOe, sckOe, sdoOe, selOut, sckOut, sdoOut, busy, reqReady},
          8'b11100010);
    if (poke) begin
      repeat (20) @(negedge clk);
      reqValid = 1'b1; reqWrite = ~w; reqTable = ~t; reqAddr = ~a; reqWdata = ~d;
      @(negedge clk) reqValid = 1'b0;
    end
    wait_n = 0;
    while (busy && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check(wait_n < 5000, "R7 watchdog", wait_n, 0);
    // R10: pulse in the cycle busy falls, pins released
    check(rspValid && !selOe && !sckOe && !sdoOe, "R10 done strobe and release",
          {rspValid, selOe, sckOe, sdoOe}, 4'b1000);
    @(negedge clk);
    check(!rspValid && rspCnt == 1, "R10 single pulse", rspCnt, 1);
    if (w) begin
      check(capBits[28:0] == {1'b1, 2'b01, a, d, 2'b00}, "R2 write frame",
            capBits[28:0], {1'b1, 2'b01, a, d, 2'b00});
      check(oeEdges == 29, "R2 driven edges", oeEdges, 29);
      check(selEdges == 27, "R3 write select", selEdges, 27);
      check(edgeCnt == 29, "R6 write edges", edgeCnt, 29);
      check(busyCyc == 60 * P, "R7 write length", busyCyc, 60 * P);
      check(rspData == lastRead, "R10 write keeps data", rspData, lastRead);
    end else begin
      expR = expResult(t, a, word);
      check(capBits[45:0] == expRdFrame(t, a), "R4 read frame", capBits[45:0], expRdFrame(t, a));
      check(oeEdges == 46, "R5 release after frame", oeEdges, 46);
      check(selEdges == 0, "R3 read select low", selEdges, 0);
      check(edgeCnt == 82, "R6 read edges", edgeCnt, 82);
      check(busyCyc == 167 * P, "R7 read length", busyCyc, 167 * P);
      check(gotRsp == expR && rspData == expR, "R8 R5 read result", rspData, expR);
      lastRead = expR;
    end
    if (poke) begin
      repeat (10) @(negedge clk);
      check(!busy && reqReady, "R9 busy request ignored", busy, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1f2e);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!selOe && !sckOe && !sdoOe && !busy && reqReady && !rspValid, "R1 reset state",
          {selOe, sckOe, sdoOe, busy, reqReady, rspValid}, 6'b000010);
    runTxn(1'b1, 1'b0, 8'hA5, 16'h1234, 32'h0, 1'b0);
    runTxn(1'b0, 1'b0, 8'h03, 16'h0, 32'hCAFE_5A5A, 1'b0);
    runTxn(1'b0, 1'b0, 8'h04, 16'h0, 32'h8001_7FFE, 1'b0);
    runTxn(1'b0, 1'b1, 8'h7F, 16'h0, 32'hDEAD_BEEF, 1'b0);
    runTxn(1'b1, 1'b0, 8'hFF, 16'hFFFF, 32'h0, 1'b0);
    runTxn(1'b0, 1'b0, 8'h00, 16'h0, 32'h0000_0001, 1'b1);
    runTxn(1'b1, 1'b0, 8'h12, 16'h8001, 32'h0, 1'b1);
    for (int i = 0; i < 10; i++) begin
      runTxn(1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom), $urandom, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule